// File: doc/BRIEF.md
# UART FIFO Controller with Loopback

This block is the buffering and interrupt core of a 16550-style serial port. A byte-wide register port feeds a transmit queue and drains a receive queue. A fixed-divider serializer and deserializer carry frames on a TX/RX pin pair. One interrupt line reports the highest-priority pending cause, and an interrupt-identification register names that cause.

Both queues are 16 entries deep when the FIFO enable bit is set. When it is clear, each queue shrinks to a single holding byte. A receive trigger level decides when enough data has arrived to raise the receive interrupt. Write-one pulse bits in the FIFO control register empty a queue. For the receive queue, that pulse resets the read pointer, write pointer and occupancy count in the same edge. The trigger comparison works on that count, so the receive interrupt can never stay asserted with nothing left to read.

A loopback bit in the modem control register feeds the serializer output straight into the deserializer. Software can then push a byte through the whole path and read it back while the external TX pin rests high.

Top module: `uart_fifo_loop`

Register map (addr): 0 data (write: transmit queue, read: pops receive queue), 1 interrupt enable (bit0 receive data, bit1 transmit empty, bit2 line status), 2 write: FIFO control / read: interrupt identification, 3 modem control (bit0 loopback), 4 line status (read clears overrun).

## Requirements
- R1: FIFO control bit 0 selects 16-entry queues (1) or single-byte holding registers (0). Writing a value that changes this bit empties both queues. Occupancy never exceeds 16.
- R2: Writing FIFO control with bit 1 set empties the receive queue and its trigger state within one edge. On the next cycle, line status bit 0 is 0, the receive interrupt is off, and later characters arrive in order.
- R3: Writing FIFO control with bit 2 set empties the transmit queue on the next edge. A character already being shifted out still completes.
- R4: FIFO control bits 7:6 set the receive trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. With FIFOs disabled the level is 1.
- R5: The receive interrupt is pending when interrupt-enable bit 0 is set and the receive count is at least the trigger level. It drops on the cycle after a read takes the count below the level.
- R6: The receive-data identification code is never reported while the receive queue is empty.
- R7: With modem control bit 0 set, transmitted frames enter the receiver and the txd pin stays high.
- R8: Line status bit 0 is 1 when the receive queue is non-empty. Bit 5 is 1 when the transmit queue is empty. Bit 6 is 1 when the transmit queue is empty and the serializer is idle.
- R9: A character that completes while the receive queue is full is discarded and sets line status bit 1. That bit stays set until line status is read.
- R10: Identification register bits 3:0 carry, in priority order: 0110 (overrun with enable bit 2), 0100 (receive), 0010 (transmit queue empty with enable bit 1), and 0001 when nothing is pending. Bits 7:6 both copy the FIFO enable bit. irq is high when any cause is pending.
- R11: A frame is one low start bit, eight data bits sent least-significant bit first, and one high stop bit, each lasting BIT_CYCLES clocks. The line idles high.
- R12: After reset, line status reads 0x60, identification reads 0x01, irq is 0 and txd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on data and line status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial transmit pin |
| rxd | input | 1 | Serial receive pin |

## Verification
The bench attacks the clear pulse while the receive interrupt is active. A design that reset the pointers but left the count, or the trigger state, would keep the interrupt asserted over an empty queue or lose the order of later characters. It walks every trigger level at one entry below and exactly at the threshold, where an off-by-one would fire early or late. It fills the queue past its depth in both FIFO modes, where a wrong design would overwrite stored data instead of discarding the newcomer. It also checks that a transmit clear spares the character in flight and that loopback keeps the external pin quiet.

// File: rtl/uart_fl_pkg.sv
package uart_fl_pkg;

    localparam logic [2:0] REG_DATA = 3'd0;
    localparam logic [2:0] REG_IEN  = 3'd1;
    localparam logic [2:0] REG_IDFC = 3'd2;
    localparam logic [2:0] REG_MCTL = 3'd3;
    localparam logic [2:0] REG_LSTA = 3'd4;

    typedef enum logic [3:0] {
        ID_NONE    = 4'b0001,
        ID_LSTAT   = 4'b0110,
        ID_RXDATA  = 4'b0100,
        ID_TXEMPTY = 4'b0010
    } int_id_e;

    typedef struct packed {
        logic [1:0] trig;
        logic       clr_tx;
        logic       clr_rx;
        logic       enable;
    } fifo_ctl_t;

    typedef struct packed {
        logic temt;
        logic thre;
        logic ovr;
        logic dr;
    } line_stat_t;

    function automatic fifo_ctl_t decode_fctl(input logic [7:0] w);
        fifo_ctl_t f;
        f.trig   = w[7:6];
        f.clr_tx = w[2];
        f.clr_rx = w[1];
        f.enable = w[0];
        return f;
    endfunction

    function automatic logic [7:0] trig_level(input logic [1:0] sel, input logic en);
        logic [7:0] lv;
        if (!en) lv = 8'd1;
        else begin
            case (sel)
                2'b00:   lv = 8'd1;
                2'b01:   lv = 8'd4;
                2'b10:   lv = 8'd8;
                default: lv = 8'd14;
            endcase
        end
        return lv;
    endfunction

    function automatic logic [7:0] pack_lstat(input line_stat_t s);
        return {1'b0, s.temt, s.thre, 3'b000, s.ovr, s.dr};
    endfunction

endpackage

// File: rtl/uart_fl_fifo.sv
module uart_fl_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             limit_one,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = limit_one ? !empty : (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_fl_tx.sv
module uart_fl_tx #(
    parameter int BIT_CYCLES = 8,
    localparam int CYW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       line
);
    logic [9:0]     shreg;
    logic [3:0]     bitn;
    logic [CYW-1:0] cyc;

    assign line = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '1;
            bitn  <= '0;
            cyc   <= '0;
        end else if (!busy) begin
            if (start) begin
                shreg <= {1'b1, data, 1'b0};
                busy  <= 1'b1;
                bitn  <= '0;
                cyc   <= '0;
            end
        end else if (cyc == CYW'(BIT_CYCLES - 1)) begin
            cyc   <= '0;
            shreg <= {1'b1, shreg[9:1]};
            if (bitn == 4'd9) busy <= 1'b0;
            else              bitn <= bitn + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/uart_fl_rx.sv
module uart_fl_rx #(
    parameter int BIT_CYCLES = 8,
    localparam int CYW  = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1,
    localparam int HALF = BIT_CYCLES / 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    output logic       valid,
    output logic [7:0] data
);
    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

    rx_state_e      state;
    logic [1:0]     sync;
    logic [CYW-1:0] cyc;
    logic [2:0]     bitn;
    logic           s;

    assign s = sync[1];

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], line};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cyc   <= '0;
            bitn  <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    cyc <= '0;
                    if (!s) state <= S_START;
                end
                S_START: begin
                    if (cyc == CYW'(HALF - 1)) begin
                        cyc   <= '0;
                        bitn  <= '0;
                        state <= s ? S_IDLE : S_DATA;
                    end else cyc <= cyc + 1'b1;
                end
                S_DATA: begin
                    if (cyc == CYW'(BIT_CYCLES - 1)) begin
                        cyc  <= '0;
                        data <= {s, data[7:1]};
                        if (bitn == 3'd7) state <= S_STOP;
                        else              bitn  <= bitn + 1'b1;
                    end else cyc <= cyc + 1'b1;
                end
                default: begin
                    if (cyc == CYW'(BIT_CYCLES - 1)) begin
                        cyc   <= '0;
                        valid <= s;
                        state <= S_IDLE;
                    end else cyc <= cyc + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_fifo_loop.sv
module uart_fifo_loop
    import uart_fl_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int BIT_CYCLES = 8,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       txd,
    input  logic       rxd
);
    logic       fifo_en;
    logic [1:0] trig_sel;
    logic [2:0] ien;
    logic       loop;
    logic       ovr;

    fifo_ctl_t  fc;
    logic       fc_wr, clr_rx, clr_tx;

    logic [7:0]    tx_dout, rx_dout, rx_byte;
    logic [CW-1:0] tx_count, rx_count, level;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_busy, tx_line, tx_start, rx_valid, rx_line;
    logic          rx_pop, lsr_rd;
    logic          rx_int, ls_int, te_int;
    int_id_e       iid;
    line_stat_t    lstat;

    assign fc     = decode_fctl(wdata);
    assign fc_wr  = wr_en && (addr == REG_IDFC);
    assign clr_rx = fc_wr && (fc.clr_rx || (fc.enable != fifo_en));
    assign clr_tx = fc_wr && (fc.clr_tx || (fc.enable != fifo_en));
    assign rx_pop = rd_en && (addr == REG_DATA);
    assign lsr_rd = rd_en && (addr == REG_LSTA);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en  <= 1'b0;
            trig_sel <= 2'b00;
            ien      <= '0;
            loop     <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                REG_IEN:  ien <= wdata[2:0];
                REG_MCTL: loop <= wdata[0];
                REG_IDFC: begin
                    fifo_en  <= fc.enable;
                    trig_sel <= fc.trig;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             ovr <= 1'b0;
        else if (rx_valid && rx_full && !clr_rx) ovr <= 1'b1;
        else if (lsr_rd)                     ovr <= 1'b0;
    end

    uart_fl_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) tx_q (
        .clk(clk), .rst(rst), .clr(clr_tx), .limit_one(!fifo_en),
        .push(wr_en && (addr == REG_DATA)), .pop(tx_start), .din(wdata),
        .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uart_fl_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) rx_q (
        .clk(clk), .rst(rst), .clr(clr_rx), .limit_one(!fifo_en),
        .push(rx_valid), .pop(rx_pop), .din(rx_byte),
        .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    assign tx_start = !tx_busy && !tx_empty && !clr_tx;

    uart_fl_tx #(.BIT_CYCLES(BIT_CYCLES)) ser (
        .clk(clk), .rst(rst), .start(tx_start), .data(tx_dout),
        .busy(tx_busy), .line(tx_line)
    );

    assign rx_line = loop ? tx_line : rxd;
    assign txd     = loop ? 1'b1 : tx_line;

    uart_fl_rx #(.BIT_CYCLES(BIT_CYCLES)) des (
        .clk(clk), .rst(rst), .line(rx_line), .valid(rx_valid), .data(rx_byte)
    );

    assign level  = CW'(trig_level(trig_sel, fifo_en));
    assign rx_int = ien[0] && !rx_empty && (rx_count >= level);
    assign ls_int = ien[2] && ovr;
    assign te_int = ien[1] && tx_empty;
    assign irq    = rx_int || ls_int || te_int;

    always_comb begin
        if (ls_int)      iid = ID_LSTAT;
        else if (rx_int) iid = ID_RXDATA;
        else if (te_int) iid = ID_TXEMPTY;
        else             iid = ID_NONE;
    end

    always_comb begin
        lstat.dr   = !rx_empty;
        lstat.ovr  = ovr;
        lstat.thre = tx_empty;
        lstat.temt = tx_empty && !tx_busy;
    end

    always_comb begin
        case (addr)
            REG_DATA: rdata = rx_empty ? 8'h00 : rx_dout;
            REG_IEN:  rdata = {5'b0, ien};
            REG_IDFC: rdata = {fifo_en, fifo_en, 2'b00, iid};
            REG_MCTL: rdata = {7'b0, loop};
            REG_LSTA: rdata = pack_lstat(lstat);
            default:  rdata = 8'h00;
        endcase
    end

    logic unused_ok;
    assign unused_ok = tx_full;
endmodule

// File: rtl/uart_fifo_loop_chk.sv
module uart_fifo_loop_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          txd,
    input logic          loop,
    input logic          rx_int,
    input logic          rx_valid,
    input logic          rx_full,
    input logic          ovr,
    input logic          clr_rx,
    input logic          clr_tx,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count
);
    // R6
    rx_int_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        rx_int |-> (rx_count != '0));

    // R2
    rx_clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr_rx |=> (rx_count == '0));

    // R3
    tx_clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr_tx |=> (tx_count == '0));

    // R7
    loop_pin_idle_chk: assert property (@(posedge clk) disable iff (rst)
        loop |-> txd);

    // R9
    overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(rx_valid && rx_full));

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));
endmodule

bind uart_fifo_loop uart_fifo_loop_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst(rst), .txd(txd), .loop(loop), .rx_int(rx_int),
    .rx_valid(rx_valid), .rx_full(rx_full), .ovr(ovr), .clr_rx(clr_rx),
    .clr_tx(clr_tx), .rx_count(rx_count), .tx_count(tx_count)
);

// File: tb/uart_fifo_loop_tb.sv
module uart_fifo_loop_tb_top;
    localparam int BC = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, txd, rxd;
    logic       ext_wire = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] v;

    always #4 clk = ~clk;
    assign rxd = ext_wire ? txd : 1'b1;

    uart_fifo_loop #(.FIFO_DEPTH(16), .BIT_CYCLES(BC)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .txd(txd), .rxd(rxd)
    );

    // {fcr, chars, rx interrupt expected}
    localparam logic [13:0] VEC [9] = '{
        {8'h01, 5'd1,  1'b1},
        {8'h41, 5'd3,  1'b0},
        {8'h41, 5'd4,  1'b1},
        {8'h81, 5'd7,  1'b0},
        {8'h81, 5'd8,  1'b1},
        {8'hC1, 5'd13, 1'b0},
        {8'hC1, 5'd14, 1'b1},
        {8'hC1, 5'd16, 1'b1},
        {8'h00, 5'd1,  1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_chars(input int n);
        repeat ((n * 10 + 4) * BC + 10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        @(negedge clk);
        peek(3'd4, v); check("R12 lstat", v, 8'h60);
        peek(3'd2, v); check("R12 iid", v, 8'h01);
        check("R12 irq", {7'b0, irq}, 8'h00);
        check("R12 txd", {7'b0, txd}, 8'h01);

        // Table walk: R4 trigger levels, R7 loopback, R5/R10 codes, R1 modes
        reg_wr(3'd3, 8'h01);
        reg_wr(3'd1, 8'h01);
        for (int r = 0; r < 9; r++) begin
            logic [7:0] fcr;
            int         n;
            logic       pend;
            fcr  = VEC[r][13:6];
            n    = int'(VEC[r][5:1]);
            pend = VEC[r][0];
            reg_wr(3'd2, fcr | 8'h06);
            for (int i = 0; i < n; i++) reg_wr(3'd0, 8'(8'h30 + r * 17 + i));
            wait_chars(n);
            peek(3'd2, v);
            check("R4 iid at count", v, {fcr[0], fcr[0], 2'b00, pend ? 4'b0100 : 4'b0001});
            check("R5 irq at count", {7'b0, irq}, {7'b0, pend});
            peek(3'd4, v); check("R8 dr set", v & 8'h03, 8'h01);
            for (int i = 0; i < n; i++) begin
                reg_rd(3'd0, v);
                check("R7 loop data", v, 8'(8'h30 + r * 17 + i));
            end
            peek(3'd4, v); check("R8 dr clear", v & 8'h01, 8'h00);
            peek(3'd2, v); check("R6 no rx code when empty", v & 8'h0F, 8'h01);
        end

        // R5 deassert as soon as count drops below level
        reg_wr(3'd2, 8'h47);
        for (int i = 0; i < 4; i++) reg_wr(3'd0, 8'(8'h70 + i));
        wait_chars(4);
        check("R5 irq at 4", {7'b0, irq}, 8'h01);
        reg_rd(3'd0, v);
        check("R5 irq after read", {7'b0, irq}, 8'h00);

        // R2 clear while interrupt active
        reg_wr(3'd0, 8'h74); reg_wr(3'd0, 8'h75);
        wait_chars(2);
        check("R2 irq before clear", {7'b0, irq}, 8'h01);
        reg_wr(3'd2, 8'h43);
        peek(3'd4, v); check("R2 dr after clear", v & 8'h01, 8'h00);
        check("R2 irq after clear", {7'b0, irq}, 8'h00);
        peek(3'd2, v); check("R2 iid after clear", v, 8'hC1);
        reg_wr(3'd0, 8'h5A); reg_wr(3'd0, 8'hA5); reg_wr(3'd0, 8'h3C);
        wait_chars(3);
        check("R2 irq below level", {7'b0, irq}, 8'h00);
        reg_wr(3'd0, 8'hC3);
        wait_chars(1);
        check("R2 irq refill", {7'b0, irq}, 8'h01);
        reg_rd(3'd0, v); check("R2 order 0", v, 8'h5A);
        reg_rd(3'd0, v); check("R2 order 1", v, 8'hA5);
        reg_rd(3'd0, v); check("R2 order 2", v, 8'h3C);
        reg_rd(3'd0, v); check("R2 order 3", v, 8'hC3);

        // R9 overrun with FIFOs enabled, R10 priority
        reg_wr(3'd1, 8'h05);
        reg_wr(3'd2, 8'h07);
        for (int i = 0; i < 17; i++) reg_wr(3'd0, 8'(8'h80 + i));
        wait_chars(17);
        peek(3'd4, v); check("R9 lstat overrun", v, 8'h63);
        peek(3'd2, v); check("R10 line status first", v, 8'hC6);
        reg_rd(3'd4, v);
        peek(3'd4, v); check("R9 overrun cleared by read", v, 8'h61);
        peek(3'd2, v); check("R10 rx next", v, 8'hC4);
        for (int i = 0; i < 16; i++) begin
            reg_rd(3'd0, v);
            check("R9 kept data", v, 8'(8'h80 + i));
        end
        peek(3'd4, v); check("R9 newcomer dropped", v & 8'h01, 8'h00);

        // R1 FIFOs disabled: single holding byte, second overruns
        reg_wr(3'd2, 8'h06);
        reg_wr(3'd0, 8'h11); reg_wr(3'd0, 8'h22);
        wait_chars(2);
        peek(3'd4, v); check("R1 single byte overrun", v, 8'h63);
        reg_rd(3'd0, v); check("R1 holds first", v, 8'h11);
        reg_rd(3'd4, v);

        // R3 clear transmit queue, in-flight char finishes
        reg_wr(3'd2, 8'h07);
        reg_wr(3'd0, 8'hE1); reg_wr(3'd0, 8'hE2); reg_wr(3'd0, 8'hE3);
        reg_wr(3'd2, 8'h05);
        peek(3'd4, v); check("R3 thre set shifter busy", v & 8'h60, 8'h20);
        wait_chars(3);
        reg_rd(3'd0, v); check("R3 in flight char", v, 8'hE1);
        peek(3'd4, v); check("R3 rest dropped", v & 8'h01, 8'h00);

        // R7 txd stays high in loopback
        begin
            int lows;
            lows = 0;
            reg_wr(3'd0, 8'h00);
            repeat (12 * BC) begin
                @(negedge clk);
                if (!txd) lows++;
            end
            check("R7 txd quiet", 8'(lows), 8'h00);
            reg_rd(3'd0, v); check("R7 looped zero", v, 8'h00);
        end

        // R11 frame shape on txd, external wire to rxd; R8 status bits
        reg_wr(3'd3, 8'h00);
        ext_wire = 1'b1;
        reg_wr(3'd0, 8'h96);
        peek(3'd4, v); check("R8 thre low while queued", v & 8'h60, 8'h00);
        repeat (1 + BC / 2) @(negedge clk);
        check("R11 start bit", {7'b0, txd}, 8'h00);
        for (int b = 0; b < 8; b++) begin
            repeat (BC) @(negedge clk);
            check("R11 data bit", {7'b0, txd}, {7'b0, 1'(8'h96 >> b)});
        end
        repeat (BC) @(negedge clk);
        check("R11 stop bit", {7'b0, txd}, 8'h01);
        peek(3'd4, v); check("R8 thre set temt clear", v & 8'h60, 8'h20);
        repeat (4 * BC) @(negedge clk);
        peek(3'd4, v); check("R8 idle and ready", v, 8'h61);
        reg_rd(3'd0, v); check("R11 external path data", v, 8'h96);
        ext_wire = 1'b0;

        // R10 transmit-empty cause
        reg_wr(3'd1, 8'h02);
        peek(3'd2, v); check("R10 tx empty code", v, 8'hC2);
        check("R10 irq tx empty", {7'b0, irq}, 8'h01);
        reg_wr(3'd1, 8'h00);
        peek(3'd2, v); check("R10 none", v, 8'hC1);
        check("R10 irq off", {7'b0, irq}, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule